// File: doc/BRIEF.md
# Bunch Intensity Capture and Front-Panel Stream

This block takes one integrated intensity word per bunch slot on the 40 MHz bunch clock. Each word arrives as 12 parallel bits with a valid strobe. A bunch-crossing counter, realigned by a turn marker, gives every sample its slot number. Every sample goes straight out on a front-panel port. It is cut down to a coarse width chosen by a mode input, and it is tagged with its slot number. This stream runs all the time, whether or not anything is being recorded.

A controller records one machine turn by pulsing an arm input. Recording starts on the next turn-marked sample. It stores exactly one turn of intensities, indexed by bunch crossing, so the buffer holds intensity as a function of crossing number. The controller then drains the buffer one word per read strobe, in bunch order. While a recording or its readout is in progress, further arm pulses have no effect.

Top module: `bunch_intensity_capture`

## Requirements
- R1: The front-panel outputs `fp_out` and `bx_out` update on the clock edge that takes each valid sample, so they are visible one cycle after it. This holds with or without a capture in progress.
- R2: With `fp_mode` = 0 (fine), `fp_out` equals sample bits 11:4.
- R3: With `fp_mode` = 1 (coarse), `fp_out` equals {4'b0000, sample bits 11:8}. On a cycle with no valid sample, `fp_out` and `bx_out` keep their values.
- R4: A valid sample taken with `turn_mark` high gets crossing number 0. Each later valid sample gets the previous number plus one. After 3563 the count returns to 0 even when no marker is present. `bx_out` reports the number of the sample shown on `fp_out`.
- R5: An `arm` pulse while `busy` is 0 sets `busy` one cycle later and clears `done` and `underflow`. Writing begins with the next valid sample that carries `turn_mark`. Samples taken before that marker are not stored.
- R6: Exactly 3564 valid samples are stored, each at its crossing number. `done` rises on the edge that takes the last one. Samples that follow are not stored.
- R7: An `arm` pulse while `busy` is 1 has no effect. It does not disturb a recording, the stored data, `done`, or the readout order.
- R8: After `done`, each `rd_en` returns the next stored word on `rd_data` one cycle later, starting at crossing 0. `busy` falls on the edge that returns crossing 3563.
- R9: An `rd_en` when no stored word is pending returns 0 on `rd_data` and sets `underflow`. This covers reads after the buffer has been drained and reads before `done`. `underflow` stays set until the next accepted `arm`.
- R10: With `rst_n` low at a clock edge, `fp_out`, `bx_out`, `rd_data`, `busy`, `done` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Intensity sample present this cycle |
| smp_data | input | 12 | Integrated intensity sample |
| turn_mark | input | 1 | Marks the sample of crossing 0 |
| fp_mode | input | 1 | Front-panel width: 0 fine (8 bits), 1 coarse (4 bits) |
| arm | input | 1 | Request a one-turn recording |
| rd_en | input | 1 | Read strobe for the stored turn |
| fp_out | output | 8 | Reduced intensity of the latest sample |
| bx_out | output | 12 | Crossing number of the sample on `fp_out` |
| rd_data | output | 12 | Word returned by the last read |
| busy | output | 1 | Recording waiting, filling, or awaiting readout |
| done | output | 1 | One full turn stored |
| underflow | output | 1 | A read found no stored word pending |

## Verification
Every result of this block appears one clock after its cause: the front-panel word and slot number after a valid sample, `busy` after an accepted arm, `done` after the 3564th stored sample, and `rd_data` after each read strobe. The bench drives inputs on the falling edge. It reads results on the next falling edge, which lies exactly one rising edge later. `done` is also checked one sample before the end of the turn, to show that it does not rise early. During readout, every word is compared against the pattern the bench generated for that crossing number.

// File: rtl/bint_pkg.sv
// Package: shared state encoding and default sizes for the bunch
// intensity capture block.
package bint_pkg;

    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_TURN_LEN = 3564;
    localparam int DEF_FP_W     = 8;
    localparam int DEF_COARSE_W = 4;

    // Recording controller states.
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,   // free, may accept an arm request
        CAP_WAIT = 2'd1,   // armed, waiting for the turn marker
        CAP_FILL = 2'd2,   // storing one turn
        CAP_HOLD = 2'd3    // turn stored, awaiting readout
    } cap_state_t;

endpackage

// File: rtl/bint_bx_counter.sv
// Bunch-crossing counter.
// Gives each valid sample its crossing number. A marked sample is crossing 0.
// The count wraps after TURN_LEN-1 with or without a marker.
// Assumes TURN_LEN >= 2.
module bint_bx_counter #(
    parameter int TURN_LEN = 3564,
    localparam int BX_W = $clog2(TURN_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic            turn_mark,
    output logic [BX_W-1:0] bx_cur
);

    localparam logic [BX_W-1:0] BX_LAST = BX_W'(TURN_LEN - 1);

    logic [BX_W-1:0] bx_next_q;

    // Crossing number of the sample present this cycle.
    always_comb begin
        bx_cur = turn_mark ? '0 : bx_next_q;
    end

    // Advance the expected number of the following sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bx_next_q <= '0;
        end else if (smp_valid) begin
            bx_next_q <= (bx_cur == BX_LAST) ? '0 : bx_cur + 1'b1;
        end
    end

endmodule

// File: rtl/bint_fp_reducer.sv
// Front-panel reducer.
// Registers the top bits of each valid sample, cut to the fine or the
// coarse width, together with its crossing number.
// Assumes COARSE_W <= FP_W.
module bint_fp_reducer #(
    parameter int FP_W     = 8,
    parameter int COARSE_W = 4,
    parameter int BX_W     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [FP_W-1:0] smp_top,
    input  logic            fp_mode,
    input  logic [BX_W-1:0] bx_cur,
    output logic [FP_W-1:0] fp_out,
    output logic [BX_W-1:0] bx_out
);

    logic [FP_W-1:0] reduced;

    // Choose the width variant; the coarse word is zero-extended.
    generate
        if (COARSE_W == FP_W) begin : g_same_w
            always_comb reduced = smp_top;
        end else begin : g_narrow
            always_comb begin
                reduced = fp_mode ? {{(FP_W-COARSE_W){1'b0}}, smp_top[FP_W-1 -: COARSE_W]}
                                  : smp_top;
            end
        end
    endgenerate

    // Register the reduced sample and its tag on every valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_out <= '0;
            bx_out <= '0;
        end else if (smp_valid) begin
            fp_out <= reduced;
            bx_out <= bx_cur;
        end
    end

endmodule

// File: rtl/bint_capture.sv
// One-turn recorder.
// Armed by a request while free. It waits for a marked sample, then stores
// TURN_LEN valid samples at their crossing numbers. After that it returns
// them in crossing order, one per read strobe.
// A read with nothing pending returns zero and sets a sticky flag.
// Assumes TURN_LEN >= 2.
module bint_capture
    import bint_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TURN_LEN = 3564,
    localparam int BX_W = $clog2(TURN_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                smp_valid,
    input  logic                turn_mark,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [BX_W-1:0]     bx_cur,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                busy,
    output logic                done,
    output logic                underflow
);

    localparam logic [BX_W-1:0] BX_LAST = BX_W'(TURN_LEN - 1);

    cap_state_t          state;
    logic [BX_W-1:0]     wr_cnt;
    logic [BX_W-1:0]     rd_ptr;
    logic                wr_en;
    logic [SAMPLE_W-1:0] turn_mem [TURN_LEN];

    // Store enable: the marked sample opens the turn, later samples fill it.
    always_comb begin
        wr_en = smp_valid && ((state == CAP_WAIT && turn_mark) || state == CAP_FILL);
    end

    // Turn storage, written at the crossing number of each stored sample.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            turn_mem[bx_cur] <= smp_data;
        end
    end

    // Controller, write count, read pointer and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CAP_IDLE;
            wr_cnt    <= '0;
            rd_ptr    <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
            underflow <= 1'b0;
        end else begin
            case (state)
                CAP_IDLE: begin
                    if (arm) begin
                        state     <= CAP_WAIT;
                        done      <= 1'b0;
                        underflow <= 1'b0;
                    end
                end
                CAP_WAIT: begin
                    if (smp_valid && turn_mark) begin
                        state  <= CAP_FILL;
                        wr_cnt <= BX_W'(1);
                    end
                end
                CAP_FILL: begin
                    if (smp_valid) begin
                        wr_cnt <= wr_cnt + 1'b1;
                        if (wr_cnt == BX_LAST) begin
                            state  <= CAP_HOLD;
                            done   <= 1'b1;
                            rd_ptr <= '0;
                        end
                    end
                end
                CAP_HOLD: begin
                    if (rd_en) begin
                        rd_ptr <= rd_ptr + 1'b1;
                        if (rd_ptr == BX_LAST) begin
                            state <= CAP_IDLE;
                        end
                    end
                end
                default: state <= CAP_IDLE;
            endcase

            // Read return path: stored word while holding, zero otherwise.
            if (rd_en) begin
                if (state == CAP_HOLD) begin
                    rd_data <= turn_mem[rd_ptr];
                end else begin
                    rd_data   <= '0;
                    underflow <= 1'b1;
                end
            end
        end
    end

    // Busy whenever the recorder is not free.
    always_comb begin
        busy = (state != CAP_IDLE);
    end

endmodule

// File: rtl/bunch_intensity_capture.sv
// Top level: bunch intensity capture and front-panel stream.
// Tags each valid sample with its crossing number and streams a reduced
// copy to the front panel. On request it records one turn for readout.
// Assumes at most one sample per clock and TURN_LEN >= 2.
module bunch_intensity_capture
    import bint_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int TURN_LEN = DEF_TURN_LEN,
    parameter int FP_W     = DEF_FP_W,
    parameter int COARSE_W = DEF_COARSE_W,
    localparam int BX_W    = $clog2(TURN_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                turn_mark,
    input  logic                fp_mode,
    input  logic                arm,
    input  logic                rd_en,
    output logic [FP_W-1:0]     fp_out,
    output logic [BX_W-1:0]     bx_out,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                busy,
    output logic                done,
    output logic                underflow
);

    logic [BX_W-1:0] bx_cur;

    bint_bx_counter #(
        .TURN_LEN (TURN_LEN)
    ) u_bx (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .turn_mark (turn_mark),
        .bx_cur    (bx_cur)
    );

    bint_fp_reducer #(
        .FP_W     (FP_W),
        .COARSE_W (COARSE_W),
        .BX_W     (BX_W)
    ) u_fp (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_top   (smp_data[SAMPLE_W-1 -: FP_W]),
        .fp_mode   (fp_mode),
        .bx_cur    (bx_cur),
        .fp_out    (fp_out),
        .bx_out    (bx_out)
    );

    bint_capture #(
        .SAMPLE_W (SAMPLE_W),
        .TURN_LEN (TURN_LEN)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .smp_valid (smp_valid),
        .turn_mark (turn_mark),
        .smp_data  (smp_data),
        .bx_cur    (bx_cur),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done),
        .underflow (underflow)
    );

endmodule

// File: rtl/bint_capture_chk.sv
// Checker for the bunch intensity capture top level. It watches the ports
// only and is attached by the bind statement at the end of this file.
module bint_capture_chk #(
    parameter int SAMPLE_W = 12,
    parameter int FP_W     = 8,
    parameter int COARSE_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [FP_W-1:0]     smp_top,
    input logic                fp_mode,
    input logic                arm,
    input logic                rd_en,
    input logic [FP_W-1:0]     fp_out,
    input logic [SAMPLE_W-1:0] rd_data,
    input logic                busy,
    input logic                done,
    input logic                underflow
);

    assert_fp_fine_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && smp_valid && !fp_mode) |-> fp_out == $past(smp_top));

    assert_fp_coarse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && smp_valid && fp_mode) |->
            fp_out == {{(FP_W-COARSE_W){1'b0}}, $past(smp_top[FP_W-1 -: COARSE_W])});

    assert_fp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !smp_valid) |-> $stable(fp_out));

    assert_busy_after_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !busy) |=> (busy && !done && !underflow));

    assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> busy);

    assert_arm_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && arm && !rd_en) |=> (busy && done));

    assert_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy) |=> (rd_data == '0 && underflow));

endmodule

bind bunch_intensity_capture bint_capture_chk #(
    .SAMPLE_W (SAMPLE_W),
    .FP_W     (FP_W),
    .COARSE_W (COARSE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_top   (smp_data[SAMPLE_W-1 -: FP_W]),
    .fp_mode   (fp_mode),
    .arm       (arm),
    .rd_en     (rd_en),
    .fp_out    (fp_out),
    .rd_data   (rd_data),
    .busy      (busy),
    .done      (done),
    .underflow (underflow)
);

// File: tb/tb_bunch_intensity_capture.sv
module tb_bunch_intensity_capture;

    localparam int TURN = 3564;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        turn_mark = 1'b0;
    logic        fp_mode = 1'b0;
    logic        arm = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  fp_out;
    logic [11:0] bx_out;
    logic [11:0] rd_data;
    logic        busy;
    logic        done;
    logic        underflow;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bunch_intensity_capture dut (
        .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid), .smp_data (smp_data),
        .turn_mark (turn_mark), .fp_mode (fp_mode), .arm (arm), .rd_en (rd_en),
        .fp_out (fp_out), .bx_out (bx_out), .rd_data (rd_data), .busy (busy),
        .done (done), .underflow (underflow)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] pat(int idx, int seed);
        return 12'((idx * 37 + seed * 401 + 5) % 4096);
    endfunction

    // Apply one cycle of inputs at a falling edge; return at the next falling edge.
    task automatic cyc(logic v, logic [11:0] d, logic m, logic md, logic a, logic r);
        smp_valid = v; smp_data = d; turn_mark = m; fp_mode = md; arm = a; rd_en = r;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", "fp_out", 32'(fp_out), 0);
        check("R10", "bx_out", 32'(bx_out), 0);
        check("R10", "rd_data", 32'(rd_data), 0);
        check("R10", "busy", 32'(busy), 0);
        check("R10", "done", 32'(done), 0);
        check("R10", "underflow", 32'(underflow), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_frontpanel();
        cyc(1, 12'hABC, 1, 0, 0, 0);
        check("R2", "fine fp_out", 32'(fp_out), 32'hAB);
        check("R1", "bx tag", 32'(bx_out), 0);
        cyc(1, 12'h5E7, 0, 1, 0, 0);
        check("R3", "coarse fp_out", 32'(fp_out), 32'h05);
        cyc(0, 12'hFFF, 0, 0, 0, 0);
        check("R3", "hold fp_out", 32'(fp_out), 32'h05);
        check("R3", "hold bx_out", 32'(bx_out), 1);
        cyc(1, 12'h3F0, 0, 0, 0, 0);
        check("R2", "fine fp_out 2", 32'(fp_out), 32'h3F);
        check("R1", "no capture busy", 32'(busy), 0);
    endtask

    task automatic t_bx_wrap();
        cyc(1, 12'h100, 1, 0, 0, 0);
        check("R4", "marker bx", 32'(bx_out), 0);
        for (int k = 1; k <= TURN + 1; k++) begin
            cyc(1, pat(k, 3), 0, 0, 0, 0);
            if (k == TURN - 1) check("R4", "last bx", 32'(bx_out), TURN - 1);
            if (k == TURN)     check("R4", "wrap bx", 32'(bx_out), 0);
            if (k == TURN + 1) check("R4", "after wrap bx", 32'(bx_out), 1);
        end
        cyc(1, 12'h200, 1, 0, 0, 0);
        check("R4", "mid-turn marker bx", 32'(bx_out), 0);
    endtask

    task automatic t_capture();
        int bad_words = 0;
        cyc(0, 12'h000, 0, 0, 1, 0);
        check("R5", "busy after arm", 32'(busy), 1);
        check("R5", "done after arm", 32'(done), 0);
        for (int k = 0; k < 5; k++) cyc(1, pat(k, 9), 0, 0, 0, 0);
        check("R5", "waiting, done", 32'(done), 0);
        for (int i = 0; i < TURN; i++) begin
            if (i == 2000) cyc(0, 12'hFFF, 0, 0, 0, 0);
            cyc(1, pat(i, 1), i == 0, 0, i == 100, 0);
            if (i == 10) check("R1", "fp during capture", 32'(fp_out), 32'(pat(10, 1) >> 4));
            if (i == TURN - 2) check("R6", "done not early", 32'(done), 0);
        end
        check("R6", "done after full turn", 32'(done), 1);
        check("R7", "arm during fill ignored, busy", 32'(busy), 1);
        for (int k = 0; k < 5; k++) cyc(1, pat(k, 2), k == 0, 0, 0, 0);
        cyc(0, 12'h000, 0, 0, 1, 0);
        check("R7", "arm in hold, done kept", 32'(done), 1);
        check("R7", "arm in hold, busy kept", 32'(busy), 1);
        for (int i = 0; i < TURN; i++) begin
            cyc(0, 12'h000, 0, 0, 0, 1);
            if (rd_data !== pat(i, 1)) begin
                bad_words++;
                if (bad_words < 5)
                    $display("FAIL R8 word %0d: actual %0h expected %0h", i, rd_data, pat(i, 1));
            end
            if (i == TURN - 2) check("R8", "busy before last read", 32'(busy), 1);
        end
        check("R6", "stored words mismatching", 32'(bad_words), 0);
        check("R8", "busy after drain", 32'(busy), 0);
        check("R8", "no underflow yet", 32'(underflow), 0);
    endtask

    task automatic t_underflow();
        cyc(0, 12'h000, 0, 0, 0, 1);
        check("R9", "drained read data", 32'(rd_data), 0);
        check("R9", "underflow set", 32'(underflow), 1);
        cyc(0, 12'h000, 0, 0, 0, 0);
        check("R9", "underflow sticky", 32'(underflow), 1);
        cyc(0, 12'h000, 0, 0, 1, 0);
        check("R9", "underflow cleared by arm", 32'(underflow), 0);
        check("R5", "done cleared by arm", 32'(done), 0);
        cyc(0, 12'h000, 0, 0, 0, 1);
        check("R9", "early read data", 32'(rd_data), 0);
        check("R9", "early read underflow", 32'(underflow), 1);
        check("R9", "still busy", 32'(busy), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_frontpanel();
        t_bx_wrap();
        t_capture();
        t_underflow();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule